// File: doc/BRIEF.md
# Start-Up Delay and Enable Sequencer

This block gates a switching power controller on and off. It takes three enable flags from analog comparators outside the block: supply above its undervoltage limit, internal reference settled, and an external remote-on request. It produces an active-low system reset for the rest of the controller. Operation starts only after all three flags have stayed true for a fixed number of oscillator cycles. The number defaults to 32 and is counted on a one-clock oscillator tick pulse. Operation stops with no counting as soon as any flag drops.

The flags are asynchronous, so each one passes through a two-flop synchronizer before the counter sees it. The counter returns to zero whenever any flag is low. As a result, either a release from undervoltage or a fresh remote-on starts a full new count. While the controller is halted, the block forces the six gate-drive outputs low and holds a discharge request for the soft-start node. Every remote-off therefore leads to a fresh soft start on the next remote-on. All outputs are registered.

Top module: `startup_sequencer`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `sys_rst_n` is 0, `gate_out` is all zeros and `ss_discharge` is 1.
- R2: `sys_rst_n` rises only after exactly START_CYCLES (32) clocks on which `osc_tick` is high and all three synchronized flags are high. It is still 0 on the clock that samples the 32nd tick and is 1 on the clock after it.
- R3: When any flag goes low, the start-up count returns to zero. When the flags return (undervoltage release or remote-on), a full new count of START_CYCLES ticks is needed, whatever the count was before.
- R4: A falling flag brings `sys_rst_n` to 0 on the third clock edge after the change (two synchronizer stages plus the output register). This happens with no oscillator ticks.
- R5: While running, `gate_out` equals `gate_in` one clock later. While halted, `gate_out` is all zeros regardless of `gate_in`.
- R6: `ss_discharge` is 1 whenever the controller is halted. This covers remote-off and the start-up count, so it stays 1 until the count completes. It is 0 while running.
- R7: While `uv_ok` is low, `remote_on` and `osc_tick` cannot take `sys_rst_n` high, however many ticks arrive.
- R8: Once running, further ticks keep the controller running; the count saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-clock pulse per oscillator cycle, synchronous to clk |
| uv_ok | input | 1 | Asynchronous flag: supply above undervoltage limit |
| ref_ok | input | 1 | Asynchronous flag: reference settled |
| remote_on | input | 1 | Asynchronous flag: remote enable request |
| gate_in | input | 6 | Gate-drive requests from the phase modulator |
| sys_rst_n | output | 1 | Active-low system reset, 1 while running |
| ss_discharge | output | 1 | Soft-start discharge request, 1 while halted |
| gate_out | output | 6 | Gated gate-drive outputs |

## Verification
Suppose the counter were off by one, did not clear on a dropped flag, or wrapped instead of saturating. The error would appear at `sys_rst_n` exactly one tick early or late around the 32nd tick, or as a start after only part of a count following a brief flag dropout. The first effect is visible on the clock after the offending tick. A missing or extra synchronizer stage shifts the halt edge by a clock, so the bench checks the exact edge of the halt as well as its level. A gating fault shows at `gate_out` within one clock of a change in `gate_in`.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Position of each enable flag on the synchronized flag vector.
  typedef enum int {
    FLAG_UV  = 0,
    FLAG_REF = 1,
    FLAG_REM = 2
  } flag_idx_e;

  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/seq_flag_sync.sv
module seq_flag_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/seq_start_counter.sv
module seq_start_counter #(
  parameter int START_CYCLES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic ok_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(START_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(START_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !ok_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = (cnt_q == LAST);

  // R3: a missing enable empties the count by the next clock
  assert_cnt_clear_R3: assert property (@(posedge clk) disable iff (rst)
    !ok_i |=> (cnt_q == '0));

  // R8: the count saturates and never passes its limit
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R2: each step of the count is caused by a tick
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ok_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/seq_out_stage.sv
module seq_out_stage #(
  parameter int N_GATES = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ok_i,
  input  logic               done_i,
  input  logic [N_GATES-1:0] gate_i,
  output logic               run_o,
  output logic               dis_o,
  output logic [N_GATES-1:0] gate_o
);
  logic               run_q;
  logic               dis_q;
  logic [N_GATES-1:0] gate_q;
  logic               run_d;

  assign run_d = ok_i && done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      dis_q  <= 1'b1;
      gate_q <= '0;
    end else begin
      run_q  <= run_d;
      dis_q  <= !run_d;
      gate_q <= run_d ? gate_i : '0;
    end
  end

  assign run_o  = run_q;
  assign dis_o  = dis_q;
  assign gate_o = gate_q;

  // R4: a dropped enable halts on the very next clock
  assert_halt_fast_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ok_i) |=> !run_q);

  // R2: start only when the count had completed with all enables present
  assert_start_counted_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> $past(ok_i && done_i));

  // R5: no gate drive while halted
  assert_halt_gates_R5: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (gate_q == '0));
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer #(
  parameter int START_CYCLES = 32,
  parameter int SYNC_STAGES  = 2,
  parameter int N_GATES      = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               osc_tick,
  input  logic               uv_ok,
  input  logic               ref_ok,
  input  logic               remote_on,
  input  logic [N_GATES-1:0] gate_in,
  output logic               sys_rst_n,
  output logic               ss_discharge,
  output logic [N_GATES-1:0] gate_out
);
  import seq_pkg::*;

  logic [NUM_FLAGS-1:0] flags_async;
  logic [NUM_FLAGS-1:0] flags_s;
  logic                 all_ok;
  logic                 cnt_done;

  always_comb begin
    flags_async           = '0;
    flags_async[FLAG_UV]  = uv_ok;
    flags_async[FLAG_REF] = ref_ok;
    flags_async[FLAG_REM] = remote_on;
  end

  seq_flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (flags_async),
    .sync_o  (flags_s)
  );

  assign all_ok = &flags_s;

  seq_start_counter #(.START_CYCLES(START_CYCLES)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .ok_i   (all_ok),
    .tick_i (osc_tick),
    .done_o (cnt_done)
  );

  seq_out_stage #(.N_GATES(N_GATES)) u_out (
    .clk    (clk),
    .rst    (rst),
    .ok_i   (all_ok),
    .done_i (cnt_done),
    .gate_i (gate_in),
    .run_o  (sys_rst_n),
    .dis_o  (ss_discharge),
    .gate_o (gate_out)
  );

  // R7: undervoltage blocks operation regardless of remote and ticks
  assert_uv_block_R7: assert property (@(posedge clk) disable iff (rst)
    !flags_s[FLAG_UV] |=> !sys_rst_n);

  // R6: the soft-start node is discharged while remote is off
  assert_remote_discharge_R6: assert property (@(posedge clk) disable iff (rst)
    !flags_s[FLAG_REM] |=> ss_discharge);
endmodule

// File: tb/startup_sequencer_tb.sv
module startup_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic       uv_ok = 1'b0;
  logic       ref_ok = 1'b0;
  logic       remote_on = 1'b0;
  logic [5:0] gate_in = '0;
  logic       sys_rst_n;
  logic       ss_discharge;
  logic [5:0] gate_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  startup_sequencer u_dut (
    .clk          (clk),
    .rst          (rst),
    .osc_tick     (osc_tick),
    .uv_ok        (uv_ok),
    .ref_ok       (ref_ok),
    .remote_on    (remote_on),
    .gate_in      (gate_in),
    .sys_rst_n    (sys_rst_n),
    .ss_discharge (ss_discharge),
    .gate_out     (gate_out)
  );

  // {uv, ref, remote}, ticks[5:0], expected sys_rst_n, expected ss_discharge
  localparam int NV = 13;
  localparam logic [10:0] VEC [NV] = '{
    11'b111_001010_01,  // R2 partial count
    11'b111_010110_10,  // R2 count completes at 32
    11'b111_000101_10,  // R8 saturate
    11'b110_000000_01,  // R6 remote off
    11'b111_011111_01,  // R3 fresh count, 31 ticks
    11'b111_000001_10,  // R2 32nd tick
    11'b011_101000_01,  // R7 uv low, ticks ignored
    11'b010_000000_01,  // R7 remote off under uv
    11'b011_101000_01,  // R7 remote on under uv
    11'b111_011111_01,  // R3 uv release restarts count
    11'b111_000001_10,  // R2
    11'b101_000000_01,  // R4 reference lost
    11'b111_100000_10   // R2 full count
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      osc_tick = 1'b1;
      @(negedge clk);
      osc_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    step(2);
    chk("R1 reset sys_rst_n", 32'(sys_rst_n), 0);
    chk("R1 reset gate_out", 32'(gate_out), 0);
    chk("R1 reset ss_discharge", 32'(ss_discharge), 1);
    rst = 1'b0;
    gate_in = 6'h15;
    step(1);
    chk("R1 after reset sys_rst_n", 32'(sys_rst_n), 0);

    for (int v = 0; v < NV; v++) begin
      {uv_ok, ref_ok, remote_on} = VEC[v][10:8];
      step(3);
      ticks(int'(VEC[v][7:2]));
      step(2);
      chk($sformatf("R2/R3/R7 vec %0d sys_rst_n", v), 32'(sys_rst_n), 32'(VEC[v][1]));
      chk($sformatf("R6 vec %0d ss_discharge", v), 32'(ss_discharge), 32'(VEC[v][0]));
      chk($sformatf("R5 vec %0d gate_out", v), 32'(gate_out), VEC[v][1] ? 32'h15 : 32'h0);
    end

    // R5: gates follow one clock later while running
    gate_in = 6'h2A;
    step(1);
    chk("R5 gate follow", 32'(gate_out), 32'h2A);

    // R4: halt latency is exactly three edges, no ticks
    remote_on = 1'b0;
    gate_in = 6'h3F;
    step(2);
    chk("R4 still running after two edges", 32'(sys_rst_n), 1);
    step(1);
    chk("R4 halted on third edge", 32'(sys_rst_n), 0);
    chk("R5 halted gates low", 32'(gate_out), 0);
    chk("R6 discharge on remote off", 32'(ss_discharge), 1);

    // R3: brief undervoltage mid-count restarts the count
    remote_on = 1'b1;
    step(3);
    ticks(20);
    uv_ok = 1'b0;
    step(4);
    uv_ok = 1'b1;
    step(3);
    ticks(12);
    chk("R3 no start after partial counts", 32'(sys_rst_n), 0);
    ticks(19);
    chk("R3 no start at 31 ticks", 32'(sys_rst_n), 0);
    // R2: exact edge of release
    osc_tick = 1'b1;
    step(1);
    osc_tick = 1'b0;
    chk("R2 low on clock of 32nd tick", 32'(sys_rst_n), 0);
    step(1);
    chk("R2 high one clock later", 32'(sys_rst_n), 1);
    chk("R6 discharge released", 32'(ss_discharge), 0);

    // R1: reset while running
    rst = 1'b1;
    step(1);
    chk("R1 mid-run reset sys_rst_n", 32'(sys_rst_n), 0);
    chk("R1 mid-run reset gate_out", 32'(gate_out), 0);
    chk("R1 mid-run reset ss_discharge", 32'(ss_discharge), 1);
    rst = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule